// File: doc/BRIEF.md
# Stream Cipher Keystream Tap and State Loader

This block keeps the five 32-bit working words of a word-oriented stream cipher. It also forms the keystream word of each block and applies it to one data word. A load strobe seeds the five words from the key and the nonce. The same strobe clears a four-entry history of the fifth word. After that, each completed block is signalled by a done strobe. The done strobe copies the final words from an external round datapath into the state and pushes the outgoing fifth word into the history.

The keystream for the current block is the sum, modulo 2^32, of two words:
- the intermediate fifth word that the round datapath presents for this block;
- the fifth word as it stood four blocks earlier.

The block XORs that sum with the incoming data word. In encrypt mode the round datapath is fed the masked plaintext as its mixing word. In decrypt mode it is fed the recovered, masked plaintext, so the same block can finish its second half-round. Bytes beyond the valid count are forced to zero in both outputs, whatever the keystream holds there. The round mixing itself lies outside this block.

The key port carries only key words 3 to 7, because key words 0 to 2 take no part in the load.

Top module: `ks_tap_loader`

## Requirements
- R1: After reset, `state_o` is all zeros and every history entry is zero, so `data_o` equals `data_i ^ y4_i` for a valid count of 4.
- R2: One cycle after `load_i`, state word j (j = 0..3, bits [32j+31:32j] of `state_o`) equals key word j+3 XOR nonce word j. Key word 3+m is at `key_win_i[32m+31:32m]` and nonce word j is at `nonce_i[32j+31:32j]`.
- R3: One cycle after `load_i`, state word 4 (bits [159:128] of `state_o`) equals key word 7 (`key_win_i[159:128]`).
- R4: For the first four blocks after a load, the delayed term of the keystream is zero, so the keystream equals `y4_i`.
- R5: With `block_done_i` high and `load_i` low, `state_o` takes `z_final_i` on the next cycle. With both strobes low, `state_o` holds.
- R6: The keystream equals `y4_i` plus the word 4 of `state_o` that was present four `block_done_i` events earlier, modulo 2^32.
- R7: When `decrypt_i` is 0, `data_o` is `data_i` XOR keystream and `mix_o` is `data_i`, both under the byte mask.
- R8: When `decrypt_i` is 1, `data_o` and `mix_o` are both `data_i` XOR keystream, under the byte mask.
- R9: `byte_cnt_i` (1 to 4) gives the number of valid bytes, counted from byte 0, the least significant byte. Bytes at index byte_cnt_i or above read as zero in `data_o` and `mix_o`.
- R10: When `load_i` and `block_done_i` are high in the same cycle, the load wins: the state takes the seed values and the history is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | Seed the state from key and nonce, and clear the history |
| key_win_i | input | 160 | Key words 3..7; word 3+m in bits [32m+31:32m] |
| nonce_i | input | 128 | Nonce words 0..3 |
| block_done_i | input | 1 | Current block finished: take the final words and advance the history |
| decrypt_i | input | 1 | 1 = decrypt, 0 = encrypt |
| y4_i | input | 32 | Intermediate fifth word of the current block |
| z_final_i | input | 160 | Final state words of the current block, word j in bits [32j+31:32j] |
| data_i | input | 32 | Plaintext (encrypt) or ciphertext (decrypt) |
| byte_cnt_i | input | 3 | Valid byte count, 1 to 4 |
| data_o | output | 32 | Masked result of data XOR keystream |
| mix_o | output | 32 | Masked plaintext word for the second half-round |
| state_o | output | 160 | Current five state words |

## Verification
A wrong seed or a missed state update shows on `state_o` one cycle after the strobe. A fault in the history stays hidden while the delayed term is zero. It appears in `data_o` only on the fifth block after a load, so the bench runs well past four blocks and keeps checking the keystream on every block. Mask and mode faults show in the same cycle as the inputs, so every valid count is exercised in both directions.

// File: rtl/ks_tap_pkg.sv
// Shared sizes and helpers for the keystream tap and state loader.
// Assumes byte-granular words (WORD_W a multiple of 8).
package ks_tap_pkg;
    localparam int WORD_W      = 32;
    localparam int NUM_STATE   = 5;
    localparam int NONCE_WORDS = 4;
    localparam int HIST_DEPTH  = 4;
    localparam int BYTES       = WORD_W / 8;
    localparam int CNT_W       = $clog2(BYTES) + 1;

    // Builds a keep mask with the low 'cnt' bytes set.
    function automatic logic [WORD_W-1:0] byte_keep(input logic [CNT_W-1:0] cnt);
        logic [WORD_W-1:0] m;
        for (int b = 0; b < BYTES; b++) begin
            m[8*b +: 8] = (b < int'(cnt)) ? 8'hFF : 8'h00;
        end
        return m;
    endfunction
endpackage

// File: rtl/ks_state_regs.sv
// Working state register bank.
// Seeds word j (j < N-1) from key-window word j XOR nonce word j, and the
// last word from the last key-window word. Takes the final words on a
// block-done strobe. The load strobe wins over block-done.
// Assumes NN >= N-1.
module ks_state_regs #(
    parameter int W  = ks_tap_pkg::WORD_W,
    parameter int N  = ks_tap_pkg::NUM_STATE,
    parameter int NN = ks_tap_pkg::NONCE_WORDS
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_i,
    input  logic           done_i,
    input  logic [N*W-1:0] key_win_i,
    input  logic [NN*W-1:0] nonce_i,
    input  logic [N*W-1:0] z_final_i,
    output logic [N*W-1:0] state_o
);
    logic [N*W-1:0] seed;
    logic [N*W-1:0] state_q;

    // Seed words: key XOR nonce for the leading words, plain key for the last.
    generate
        for (genvar j = 0; j < N; j++) begin : g_seed
            if (j < N - 1) begin : g_mix
                assign seed[j*W +: W] = key_win_i[j*W +: W] ^ nonce_i[j*W +: W];
            end else begin : g_last
                assign seed[j*W +: W] = key_win_i[j*W +: W];
            end
        end
    endgenerate

    // State update: reset, then load, then block completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else if (load_i) begin
            state_q <= seed;
        end else if (done_i) begin
            state_q <= z_final_i;
        end
    end

    assign state_o = state_q;

    // Checks on the seeding of each mixed word.
    generate
        for (genvar j = 0; j < N - 1; j++) begin : g_chk
            assert_seed_mix_R2: assert property (@(posedge clk) disable iff (!rst_n)
                load_i |=> state_o[j*W +: W] == $past(key_win_i[j*W +: W] ^ nonce_i[j*W +: W]));
        end
    endgenerate

    assert_seed_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> state_o[(N-1)*W +: W] == $past(key_win_i[(N-1)*W +: W]));

    assert_take_final_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !load_i) |=> state_o == $past(z_final_i));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_i && !load_i) |=> $stable(state_o));

    // The load strobe must win over block-done in the same cycle.
    assert_load_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && done_i) |=> state_o == $past(seed));
endmodule

// File: rtl/ks_history.sv
// Delay line of the fifth state word, D entries deep.
// Stage 0 is the newest entry and stage D-1 the oldest. The clear strobe
// zeroes every entry and wins over a shift. Assumes D >= 2.
module ks_history #(
    parameter int W = ks_tap_pkg::WORD_W,
    parameter int D = ks_tap_pkg::HIST_DEPTH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         shift_i,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] oldest_o
);
    logic [W-1:0] stage_q [D];

    // Stage 0 captures the new word.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            stage_q[0] <= '0;
        end else if (shift_i) begin
            stage_q[0] <= din_i;
        end
    end

    // Later stages pass their predecessor along.
    generate
        for (genvar k = 1; k < D; k++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n || clear_i) begin
                    stage_q[k] <= '0;
                end else if (shift_i) begin
                    stage_q[k] <= stage_q[k-1];
                end
            end
        end
    endgenerate

    assign oldest_o = stage_q[D-1];

    assert_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> oldest_o == '0);

    assert_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !clear_i) |=> oldest_o == $past(stage_q[D-2]));

    assert_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_i && !clear_i) |=> $stable(oldest_o));
endmodule

// File: rtl/ks_combine.sv
// Keystream adder and data combiner.
// The keystream is the intermediate word plus the delayed word. The data
// output is the masked data XOR keystream. The mixing output is the masked
// plaintext: the input word in encrypt mode, the XOR result in decrypt mode.
// Clock and reset are used only by the checks.
module ks_combine #(
    parameter int W     = ks_tap_pkg::WORD_W,
    parameter int CNT_W = ks_tap_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             decrypt_i,
    input  logic [W-1:0]     y4_i,
    input  logic [W-1:0]     hist_i,
    input  logic [W-1:0]     data_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [W-1:0]     data_o,
    output logic [W-1:0]     mix_o
);
    localparam int NB = W / 8;

    logic [W-1:0] ks;
    logic [W-1:0] keep;
    logic [W-1:0] xw;

    // Keystream sum and the mode-dependent selection of the masked words.
    always_comb begin
        ks     = y4_i + hist_i;
        keep   = ks_tap_pkg::byte_keep(cnt_i);
        xw     = data_i ^ ks;
        data_o = xw & keep;
        mix_o  = (decrypt_i ? xw : data_i) & keep;
    end

    // Bytes past the count must be zero in both outputs.
    generate
        for (genvar b = 1; b < NB; b++) begin : g_mask_chk
            assert_tail_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (cnt_i <= CNT_W'(b)) |-> (data_o[8*b +: 8] == 8'h00 && mix_o[8*b +: 8] == 8'h00));
        end
    endgenerate

    assert_dec_feed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        decrypt_i |-> mix_o == data_o);

    assert_enc_feed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!decrypt_i && cnt_i == CNT_W'(NB)) |-> mix_o == data_i);
endmodule

// File: rtl/ks_tap_loader.sv
// Top of the keystream tap and state loader.
// Holds the working state words and the history of the fifth word, and
// combines the keystream with one data word per block. The round datapath
// is external. Assumes byte_cnt_i stays in 1..BYTES.
module ks_tap_loader #(
    parameter int W  = ks_tap_pkg::WORD_W,
    parameter int N  = ks_tap_pkg::NUM_STATE,
    parameter int NN = ks_tap_pkg::NONCE_WORDS,
    parameter int D  = ks_tap_pkg::HIST_DEPTH,
    parameter int CW = ks_tap_pkg::CNT_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [N*W-1:0]  key_win_i,
    input  logic [NN*W-1:0] nonce_i,
    input  logic            block_done_i,
    input  logic            decrypt_i,
    input  logic [W-1:0]    y4_i,
    input  logic [N*W-1:0]  z_final_i,
    input  logic [W-1:0]    data_i,
    input  logic [CW-1:0]   byte_cnt_i,
    output logic [W-1:0]    data_o,
    output logic [W-1:0]    mix_o,
    output logic [N*W-1:0]  state_o
);
    logic [W-1:0] delayed;

    ks_state_regs #(.W(W), .N(N), .NN(NN)) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load_i),
        .done_i    (block_done_i),
        .key_win_i (key_win_i),
        .nonce_i   (nonce_i),
        .z_final_i (z_final_i),
        .state_o   (state_o)
    );

    ks_history #(.W(W), .D(D)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (load_i),
        .shift_i  (block_done_i),
        .din_i    (state_o[(N-1)*W +: W]),
        .oldest_o (delayed)
    );

    ks_combine #(.W(W), .CNT_W(CW)) u_comb (
        .clk       (clk),
        .rst_n     (rst_n),
        .decrypt_i (decrypt_i),
        .y4_i      (y4_i),
        .hist_i    (delayed),
        .data_i    (data_i),
        .cnt_i     (byte_cnt_i),
        .data_o    (data_o),
        .mix_o     (mix_o)
    );
endmodule

// File: tb/ks_tap_loader_tb_top.sv
`timescale 1ns/1ps
module ks_tap_loader_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_i = 1'b0;
    logic [159:0] key_win_i = '0;
    logic [127:0] nonce_i = '0;
    logic         block_done_i = 1'b0;
    logic         decrypt_i = 1'b0;
    logic [31:0]  y4_i = '0;
    logic [159:0] z_final_i = '0;
    logic [31:0]  data_i = '0;
    logic [2:0]   byte_cnt_i = 3'd4;
    logic [31:0]  data_o;
    logic [31:0]  mix_o;
    logic [159:0] state_o;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [31:0]  d;
        logic [31:0]  m;
        logic [159:0] s;
        string        tag;
    } exp_t;
    exp_t q[$];

    // Bench model of the state and history, built from the requirements.
    logic [31:0] mst [5];
    logic [31:0] mh  [4];

    always #2.5 clk = ~clk;

    ks_tap_loader dut_i (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .key_win_i(key_win_i),
        .nonce_i(nonce_i), .block_done_i(block_done_i), .decrypt_i(decrypt_i),
        .y4_i(y4_i), .z_final_i(z_final_i), .data_i(data_i),
        .byte_cnt_i(byte_cnt_i), .data_o(data_o), .mix_o(mix_o), .state_o(state_o)
    );

    // Driver: applies one cycle of stimulus, predicts the outputs, updates the model.
    task automatic step(input bit ld, input bit dn, input bit dec, input logic [31:0] y4,
                        input logic [159:0] zf, input logic [31:0] din,
                        input logic [2:0] cnt, input string tag);
        logic [31:0] ks, keep, xw;
        logic [159:0] s;
        exp_t e;
        @(negedge clk);
        load_i = ld; block_done_i = dn; decrypt_i = dec; y4_i = y4;
        z_final_i = zf; data_i = din; byte_cnt_i = cnt;
        #1;
        ks = y4 + mh[3];
        for (int b = 0; b < 4; b++) keep[8*b +: 8] = (b < int'(cnt)) ? 8'hFF : 8'h00;
        xw = din ^ ks;
        for (int j = 0; j < 5; j++) s[32*j +: 32] = mst[j];
        e.d = xw & keep;
        e.m = (dec ? xw : din) & keep;
        e.s = s;
        e.tag = tag;
        q.push_back(e);
        if (ld) begin
            for (int j = 0; j < 4; j++) mst[j] = key_win_i[32*j +: 32] ^ nonce_i[32*j +: 32];
            mst[4] = key_win_i[159:128];
            for (int k = 0; k < 4; k++) mh[k] = '0;
        end else if (dn) begin
            for (int k = 3; k > 0; k--) mh[k] = mh[k-1];
            mh[0] = mst[4];
            for (int j = 0; j < 5; j++) mst[j] = zf[32*j +: 32];
        end
    endtask

    // Monitor: pops predictions and compares them with the ports.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks += 3;
                if (data_o !== e.d) begin
                    errors++;
                    $display("FAIL %s data_o actual %h expected %h", e.tag, data_o, e.d);
                end
                if (mix_o !== e.m) begin
                    errors++;
                    $display("FAIL %s mix_o actual %h expected %h", e.tag, mix_o, e.m);
                end
                if (state_o !== e.s) begin
                    errors++;
                    $display("FAIL %s state_o actual %h expected %h", e.tag, state_o, e.s);
                end
            end
        end
    end

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Stimulus sequence.
    initial begin
        void'($urandom(7));
        for (int j = 0; j < 5; j++) mst[j] = '0;
        for (int k = 0; k < 4; k++) mh[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset leaves a zero state and a zero history.
        step(0, 0, 0, 32'h1357_9BDF, '0, 32'hA5A5_A5A5, 3'd4, "R1");

        key_win_i = {32'h7777_0007, 32'h6666_0006, 32'h5555_0005, 32'h4444_0004, 32'h3333_0003};
        nonce_i   = {32'hF0F0_0303, 32'h0F0F_0202, 32'hAAAA_0101, 32'h1234_5678};
        step(1, 0, 0, 32'h0000_0001, '0, 32'h0, 3'd4, "R2");
        // R2 R3: seeded state visible; R4: first block keystream is y4 alone.
        step(0, 1, 0, 32'hDEAD_BEEF, {$urandom, $urandom, $urandom, $urandom, $urandom},
             32'h0102_0304, 3'd4, "R2 R3 R4");
        for (int i = 0; i < 3; i++) begin
            step(0, 1, i[0], $urandom, {$urandom, $urandom, $urandom, $urandom, $urandom},
                 $urandom, 3'd4, "R4 R5");
        end
        // R6: delayed word enters from the fifth block on, all valid counts.
        for (int i = 0; i < 12; i++) begin
            step(0, 1, i[1], $urandom, {$urandom, $urandom, $urandom, $urandom, $urandom},
                 $urandom, 3'(1 + (i % 4)), "R6 R9");
        end
        step(0, 0, 0, $urandom, '1, $urandom, 3'd4, "R7 R5");
        step(0, 0, 1, $urandom, '1, $urandom, 3'd4, "R8 R5");
        step(0, 0, 1, 32'hFFFF_FFFF, '1, 32'h0, 3'd1, "R8 R9");
        step(0, 0, 0, 32'hFFFF_FFFF, '1, 32'hFFFF_FFFF, 3'd2, "R7 R9");
        step(0, 0, 1, $urandom, '1, $urandom, 3'd3, "R8 R9");

        // R10: load and done together; the load wins and the history clears.
        key_win_i = {$urandom, $urandom, $urandom, $urandom, $urandom};
        nonce_i   = {$urandom, $urandom, $urandom, $urandom};
        step(1, 1, 0, $urandom, {$urandom, $urandom, $urandom, $urandom, $urandom},
             $urandom, 3'd4, "R10");
        step(0, 0, 0, 32'h2468_ACE0, '0, 32'h1111_1111, 3'd4, "R10 R4");
        for (int i = 0; i < 6; i++) begin
            step(0, 1, i[0], $urandom, {$urandom, $urandom, $urandom, $urandom, $urandom},
                 $urandom, 3'd4, "R6");
        end
        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule